// File: doc/BRIEF.md
# Codec Command Slot Engine

This block handles codec control traffic on an AC'97-style serial link. Each link frame carries a command-address slot and a command-data slot. The host writes these two slot words into transmit holding registers. The block places them into the next outgoing frame once the host has armed the transfer. When the codec answers, the block captures the returned status words into receive registers, and the host reads them back over a small register port.

The host has no request/acknowledge handshake. A write loads the data slot first and then the address slot, and loading the address slot arms the send. A read loads only the address slot, with its top bit set. The host then polls a flag register:

- A per-slot busy bit stays set until the word has left in a frame.
- A per-slot valid bit is set when a response frame has been captured, and reading the matching receive register clears it.

A control register gates all of this. It holds a global enable, per-slot transmit and receive enables, and a codec-select field that goes out with each frame. A separate register bit drives the codec's active-low reset line.

The link side is abstract. `frame_go` marks the point where the next outgoing frame's command slots are fixed. `rx_frame` marks a received frame together with its slot tags and words.

Top module: `aclink_cmd_port`

Register map (`reg_addr`):

| Address | Register | Access |
|---|---|---|
| 0 | CTRL | read/write |
| 1 | S1TX | read/write |
| 2 | S2TX | read/write |
| 3 | S1RX | read; the read clears the slot 1 valid bit |
| 4 | S2RX | read; the read clears the slot 2 valid bit |
| 5 | FLAGS | read; a write with bit 4 set clears the drop bit |
| 6 | CRST | read/write |

Bit fields:

| Register | Bits | Meaning |
|---|---|---|
| CTRL | [0] | global enable |
| CTRL | [1] | slot 1 transmit enable |
| CTRL | [2] | slot 2 transmit enable |
| CTRL | [3] | slot 1 receive enable |
| CTRL | [4] | slot 2 receive enable |
| CTRL | [9:8] | codec select |
| FLAGS | [0] | slot 1 busy |
| FLAGS | [1] | slot 2 busy |
| FLAGS | [2] | slot 1 valid |
| FLAGS | [3] | slot 2 valid |
| FLAGS | [4] | slot 1 drop |
| CRST | [0] | codec reset line level |

Slot word layout, 20 bits:

| Slot | Bits | Content |
|---|---|---|
| Slot 1 | [19] | read request |
| Slot 1 | [18:12] | register address |
| Slot 2 | [19:4] | data |

## Requirements
- R1: After reset, every register and flag reads 0. Both link tags are 0, `lnk_codec` is 0, and `codec_rst_n` is 0.
- R2: An armed slot word leaves unchanged on `lnk_s1_word`/`lnk_s2_word`, with its tag high, in the cycle after the `frame_go` that sends it. A frame that sends nothing drives tag 0 and word 0.
- R3: Loading S1TX or S2TX sets that slot's busy flag. The flag stays set until the frame that sends the word, and that frame clears it.
- R4: A slot is sent only while CTRL[0] and that slot's transmit enable are both 1. A word held back by the enables stays busy and leaves at the first enabled frame.
- R5: Slot 2 goes out only in a frame that also sends slot 1. A slot 2 word loaded alone stays busy until slot 1 is armed.
- R6: On `rx_frame`, a tagged slot is captured, and its valid flag set, when CTRL[0] and that slot's receive enable are 1. Otherwise the frame is ignored. Reading S1RX/S2RX returns the captured word and clears that valid flag.
- R7: A load of S1TX while slot 1 is busy is ignored, and it sets the sticky drop flag FLAGS[4]. Writing FLAGS with bit 4 set clears the drop flag.
- R8: A response captured while the previous one is unread overwrites it, and the valid flag stays set.
- R9: `codec_rst_n` follows CRST[0], so it is held low while that bit is 0.
- R10: `lnk_codec` takes the CTRL codec-select field at every `frame_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (clears receive valid for S1RX/S2RX) |
| reg_addr | input | 3 | register address |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data (combinational) |
| frame_go | input | 1 | fix command slots of the next outgoing frame |
| lnk_s1_word | output | 20 | outgoing slot 1 word |
| lnk_s2_word | output | 20 | outgoing slot 2 word |
| lnk_s1_tag | output | 1 | slot 1 carries valid data this frame |
| lnk_s2_tag | output | 1 | slot 2 carries valid data this frame |
| lnk_codec | output | 2 | codec select for the outgoing frame |
| rx_frame | input | 1 | a received frame is presented |
| rx_s1_tag | input | 1 | received slot 1 is valid |
| rx_s2_tag | input | 1 | received slot 2 is valid |
| rx_s1_word | input | 20 | received slot 1 word |
| rx_s2_word | input | 20 | received slot 2 word |
| codec_rst_n | output | 1 | active-low codec reset |

## Verification
The assertions check several rules on every cycle:

- A busy flag never drops without a sending frame.
- No tag appears when the enables are off.
- Slot 2 never leaves without slot 1.
- Valid flags persist until read.
- A load onto a busy slot raises the drop flag.
- The reset line follows writes to its register.

Only the bench scenarios can show the rest:

- The transmitted and captured words are exactly the ones loaded or presented.
- The codec select rides with the frame.
- A held word leaves once it is enabled.
- Overwrite keeps the newest response.
- The read/write command sequences complete end to end.

// File: rtl/aclink_cmd_port.sv
`timescale 1ns/1ps
module aclink_cmd_port #(
  parameter int SW   = 20,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            frame_go,
  output logic [SW-1:0]   lnk_s1_word,
  output logic [SW-1:0]   lnk_s2_word,
  output logic            lnk_s1_tag,
  output logic            lnk_s2_tag,
  output logic [SELW-1:0] lnk_codec,
  input  logic            rx_frame,
  input  logic            rx_s1_tag,
  input  logic            rx_s2_tag,
  input  logic [SW-1:0]   rx_s1_word,
  input  logic [SW-1:0]   rx_s2_word,
  output logic            codec_rst_n
);
  localparam logic [2:0] A_CTRL = 3'd0, A_S1TX = 3'd1, A_S2TX = 3'd2,
                         A_S1RX = 3'd3, A_S2RX = 3'd4, A_FLAGS = 3'd5, A_CRST = 3'd6;
  localparam int SEL_LO = 8;

  logic [SW-1:0]   s1_tx, s2_tx, s1_rx, s2_rx;
  logic [4:0]      en;
  logic [SELW-1:0] sel;
  logic            s1_busy, s2_busy, s1_vld, s2_vld, drop, crst;

  wire wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  wire wr_s1    = reg_wr && reg_addr == A_S1TX;
  wire wr_s2    = reg_wr && reg_addr == A_S2TX;
  wire wr_flags = reg_wr && reg_addr == A_FLAGS;
  wire wr_crst  = reg_wr && reg_addr == A_CRST;
  wire take1    = reg_rd && reg_addr == A_S1RX;
  wire take2    = reg_rd && reg_addr == A_S2RX;

  wire send1 = frame_go && en[0] && en[1] && s1_busy;
  wire send2 = send1 && en[2] && s2_busy;
  wire cap1  = rx_frame && en[0] && en[3] && rx_s1_tag;
  wire cap2  = rx_frame && en[0] && en[4] && rx_s2_tag;

  assign codec_rst_n = crst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0; sel <= '0; crst <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en  <= reg_wdata[4:0];
        sel <= reg_wdata[SEL_LO +: SELW];
      end
      if (wr_crst) crst <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_tx <= '0; s2_tx <= '0; s1_busy <= 1'b0; s2_busy <= 1'b0; drop <= 1'b0;
    end else begin
      if (wr_s1 && !s1_busy) begin
        s1_tx   <= reg_wdata[SW-1:0];
        s1_busy <= 1'b1;
      end else if (send1) begin
        s1_busy <= 1'b0;
      end
      if (wr_s2) begin
        s2_tx   <= reg_wdata[SW-1:0];
        s2_busy <= 1'b1;
      end else if (send2) begin
        s2_busy <= 1'b0;
      end
      if (wr_s1 && s1_busy) drop <= 1'b1;
      else if (wr_flags && reg_wdata[4]) drop <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lnk_s1_word <= '0; lnk_s2_word <= '0;
      lnk_s1_tag <= 1'b0; lnk_s2_tag <= 1'b0; lnk_codec <= '0;
    end else if (frame_go) begin
      lnk_s1_tag  <= send1;
      lnk_s2_tag  <= send2;
      lnk_s1_word <= send1 ? s1_tx : '0;
      lnk_s2_word <= send2 ? s2_tx : '0;
      lnk_codec   <= sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_rx <= '0; s2_rx <= '0; s1_vld <= 1'b0; s2_vld <= 1'b0;
    end else begin
      if (cap1) begin
        s1_rx <= rx_s1_word; s1_vld <= 1'b1;
      end else if (take1) begin
        s1_vld <= 1'b0;
      end
      if (cap2) begin
        s2_rx <= rx_s2_word; s2_vld <= 1'b1;
      end else if (take2) begin
        s2_vld <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  begin reg_rdata[4:0] = en; reg_rdata[SEL_LO +: SELW] = sel; end
      A_S1TX:  reg_rdata[SW-1:0] = s1_tx;
      A_S2TX:  reg_rdata[SW-1:0] = s2_tx;
      A_S1RX:  reg_rdata[SW-1:0] = s1_rx;
      A_S2RX:  reg_rdata[SW-1:0] = s2_rx;
      A_FLAGS: reg_rdata[4:0] = {drop, s2_vld, s1_vld, s2_busy, s1_busy};
      A_CRST:  reg_rdata[0] = crst;
      default: reg_rdata = '0;
    endcase
  end

  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    s1_busy && !frame_go |=> s1_busy);
  a_r4_gated_tag: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go && !(en[0] && en[1]) |=> !lnk_s1_tag && !lnk_s2_tag);
  a_r5_s2_rides_s1: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_s2_tag |-> lnk_s1_tag);
  a_r6_valid_until_read: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld && !take1 |=> s1_vld);
  a_r7_drop_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    wr_s1 && s1_busy |=> drop && $stable(s1_tx));
  a_r9_reset_line: assert property (@(posedge clk) disable iff (!rst_n)
    wr_crst && !reg_wdata[0] |=> !codec_rst_n);
endmodule

// File: tb/test_aclink_cmd_port.sv
`timescale 1ns/1ps
module test_aclink_cmd_port;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic frame_go = 0, rx_frame = 0, rx_s1_tag = 0, rx_s2_tag = 0;
  logic [19:0] rx_s1_word = 0, rx_s2_word = 0, lnk_s1_word, lnk_s2_word;
  logic lnk_s1_tag, lnk_s2_tag, codec_rst_n;
  logic [1:0] lnk_codec;
  int tests = 0, fails = 0;
  bit done = 0;

  aclink_cmd_port i_aclink_cmd_port (.*);

  always #10 clk = ~clk;

  function automatic logic [19:0] f_cmd(input bit rd, input logic [6:0] a);
    return {rd, a, 12'h000};
  endfunction
  function automatic logic [19:0] f_dat(input logic [15:0] d);
    return {d, 4'h0};
  endfunction
  function automatic logic [31:0] f_ctrl(input logic [4:0] e, input logic [1:0] s);
    return {22'd0, s, 3'd0, e};
  endfunction
  function automatic logic [31:0] f_flags(input bit b1, b2, v1, v2, dr);
    return {27'd0, dr, v2, v1, b2, b1};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask
  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask
  task automatic frame();
    @(negedge clk); frame_go = 1;
    @(negedge clk); frame_go = 0;
  endtask
  task automatic rxf(input bit t1, t2, input logic [19:0] w1, w2);
    @(negedge clk); rx_frame = 1; rx_s1_tag = t1; rx_s2_tag = t2; rx_s1_word = w1; rx_s2_word = w2;
    @(negedge clk); rx_frame = 0; rx_s1_tag = 0; rx_s2_tag = 0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    #45 rst_n = 1;
    // R1 reset state
    peek(3'd5, d); chk("R1 flags", d, 0);
    peek(3'd0, d); chk("R1 ctrl", d, 0);
    chk("R1 tags", {lnk_s1_tag, lnk_s2_tag, lnk_codec}, 0);
    chk("R1 codec reset", codec_rst_n, 0);
    // R9 reset line
    wr(3'd6, 1); chk("R9 release", codec_rst_n, 1);
    wr(3'd6, 0); chk("R9 hold low", codec_rst_n, 0);
    wr(3'd6, 1);
    // R2 empty frame
    wr(3'd0, f_ctrl(5'h1f, 2'd1));
    frame(); chk("R2 empty frame", {lnk_s1_tag, lnk_s2_tag, lnk_s1_word, lnk_s2_word}, 0);
    chk("R10 codec", lnk_codec, 1);

    for (int i = 0; i < 40; i++) begin
      logic [1:0] s = 2'($urandom);
      logic [6:0] a = 7'($urandom);
      logic [15:0] v = 16'($urandom);
      bit isrd = 1'($urandom);
      wr(3'd0, f_ctrl(5'h1f, s));
      if (!isrd) begin
        wr(3'd2, {12'd0, f_dat(v)});
        peek(3'd5, d); chk("R3 s2 busy", d, f_flags(0, 1, 0, 0, 0));
        frame(); chk("R5 s2 alone waits", {lnk_s1_tag, lnk_s2_tag}, 0);
        wr(3'd1, {12'd0, f_cmd(0, a)});
        peek(3'd5, d); chk("R3 both busy", d, f_flags(1, 1, 0, 0, 0));
        frame();
        chk("R2 write tags", {lnk_s1_tag, lnk_s2_tag}, 2'b11);
        chk("R2 s1 word", lnk_s1_word, f_cmd(0, a));
        chk("R2 s2 word", lnk_s2_word, f_dat(v));
        chk("R10 codec", lnk_codec, s);
        peek(3'd5, d); chk("R3 cleared", d, 0);
      end else begin
        wr(3'd1, {12'd0, f_cmd(1, a)});
        frame();
        chk("R2 read tags", {lnk_s1_tag, lnk_s2_tag}, 2'b10);
        chk("R2 read word", lnk_s1_word, f_cmd(1, a));
        rxf(1, 1, f_cmd(0, a), f_dat(v));
        peek(3'd5, d); chk("R6 valid", d, f_flags(0, 0, 1, 1, 0));
        rd(3'd3, d); chk("R6 echo", d, {12'd0, f_cmd(0, a)});
        rd(3'd4, d); chk("R6 data", d, {12'd0, f_dat(v)});
        peek(3'd5, d); chk("R6 cleared", d, 0);
      end
    end

    // R4 slot 1 transmit disabled holds word
    wr(3'd0, f_ctrl(5'h1d, 2'd0));
    wr(3'd1, {12'd0, f_cmd(1, 7'h26)});
    frame(); chk("R4 gated", lnk_s1_tag, 0);
    peek(3'd5, d); chk("R4 still busy", d, f_flags(1, 0, 0, 0, 0));
    // R7 drop while busy
    wr(3'd1, {12'd0, f_cmd(0, 7'h11)});
    peek(3'd5, d); chk("R7 drop flag", d, f_flags(1, 0, 0, 0, 1));
    wr(3'd0, f_ctrl(5'h1f, 2'd3));
    frame(); chk("R4 sent when enabled", {lnk_s1_tag, lnk_s1_word}, {1'b1, f_cmd(1, 7'h26)});
    chk("R7 first word kept", lnk_s1_word, f_cmd(1, 7'h26));
    wr(3'd5, 32'h10);
    peek(3'd5, d); chk("R7 drop cleared", d, 0);
    // R4 global disable
    wr(3'd0, f_ctrl(5'h1e, 2'd0));
    wr(3'd1, {12'd0, f_cmd(0, 7'h05)});
    frame(); chk("R4 global off", lnk_s1_tag, 0);
    // R6 receive ignored while disabled
    rxf(1, 1, 20'h12340, 20'h56780);
    peek(3'd5, d); chk("R6 ignored", d, f_flags(1, 0, 0, 0, 0));
    wr(3'd0, f_ctrl(5'h1f, 2'd0));
    frame(); chk("R4 released", lnk_s1_word, f_cmd(0, 7'h05));
    // R8 overwrite
    rxf(1, 0, 20'h11110, 20'h0);
    rxf(1, 0, 20'h22220, 20'h0);
    peek(3'd5, d); chk("R8 valid kept", d, f_flags(0, 0, 1, 0, 0));
    rd(3'd3, d); chk("R8 newest", d, 32'h22220);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule